// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an 8-bit up-counter with a selectable count clock and a compare register. Software reaches it through a small synchronous register port with address, write data, a write strobe and combinational read data. A control register selects the count source, the active edge of that source and the interrupt enable. It also holds the run bit, and it returns a match flag that is read-only and a flag-clear command. A compare register sets the terminal value. A read-only window returns the live counter value.

The count source is one of seven taps of a free-running prescaler or an external clock. The prescaler advances once per instruction tick. The external clock passes through a two-flop synchronizer. The selected level feeds an edge detector. Its edge pulse is a one-cycle enable in the system clock domain, and nothing is ever clocked by the source itself. A compare match is taken on the count edge at which the counter already equals the compare value. On that edge the counter returns to zero, the match flag rises, and the level interrupt follows the flag when it is enabled.

A three-state controller sequences the counter. In HALT the counter holds. The transition HALT→ARM is taken on a write that sets the run bit while it is clear. It zeroes the counter and the prescaler. ARM lasts exactly one cycle, so that the edge detector sees a clean history. ARM→COUNT follows unless the same cycle writes the run bit to 0, which gives ARM→HALT. COUNT→HALT is taken on any control write with the run bit at 0.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the control register (address 0), the compare register (address 1) and the counter window (address 2) all read 0x00, and `irq` is 0.
- R2: The counter holds its value while the run bit (control bit 0) is 0.
- R3: A write that sets the run bit while it is 0 zeroes the counter and the prescaler, and counting starts. Rewriting it while it is already 1 leaves the counter running without a clear.
- R4: Clock-select field (control bits 3:1) codes 0 to 6 divide the instruction tick by 2, 4, 16, 64, 128, 256 and 512. With the tick high every cycle and the start write taken on edge E0, the first rising-polarity count edge is E(D/2+1). Later count edges follow every D cycles.
- R5: Code 7 selects `ext_clk` through a two-flop synchronizer. The counter advances once per selected external edge.
- R6: With edge bit (control bit 4) at 1 the counter uses rising edges of the source. At 0 it uses falling edges, and the first internal count edge is then E(D+1).
- R7: On a count edge where the counter equals the compare value, the counter becomes 0 and the match flag (control bit 7) becomes 1. A match with compare value C therefore falls on the (C+1)-th count edge.
- R8: Writing control bit 7 has no effect on the match flag.
- R9: Writing 1 to control bit 6 clears the match flag. Writing 0 there has no effect, and bit 6 always reads 0.
- R10: When a match and a flag-clear write fall in the same cycle, the flag ends at 1.
- R11: `irq` is 0 while the enable bit (control bit 5) is 0, and it equals the match flag while that bit is 1.
- R12: The compare register at address 1 reads back what was written. Address 3 reads 0x00.
- R13: While `inst_tick` is 0 the prescaler does not advance, so the internally clocked counter does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_tick | input | 1 | One-cycle instruction tick feeding the prescaler |
| ext_clk | input | 1 | Asynchronous external count clock |
| reg_addr | input | 2 | Register address: 0 control, 1 compare, 2 counter |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A count edge that produces a match and a software write of the flag-clear bit can land on the same clock edge. The bench knows the exact edge of each match from the latency formula of R4 and R6. It times a clear write to be captured on that edge, then reads the control register and expects the flag still set. A second clear, placed well away from any match, must then take effect. This separates a set-wins priority from the opposite order.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W   = 8;
    localparam int SEL_W   = 3;
    localparam int ADDR_W  = 2;
    localparam int SYNC_N  = 2;

    localparam int B_START = 0;
    localparam int B_SEL   = 1;
    localparam int B_POL   = 4;
    localparam int B_IEN   = 5;
    localparam int B_CLR   = 6;
    localparam int B_FLAG  = 7;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

    localparam int N_INT_SRC = 7;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } tmr_state_e;

    function automatic int tap_of(logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            default: return 8;
        endcase
    endfunction

    localparam int PSC_W = tap_of(3'd6) + 1;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_lvl,
    output logic             src_lvl
);
    localparam int N_SRC = 1 << SEL_W;

    logic [PSC_W-1:0] psc_q;
    logic [N_SRC-1:0] lvl_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    psc_q <= '0;
        else if (clr)  psc_q <= '0;
        else if (tick) psc_q <= psc_q + 1'b1;
    end

    generate
        for (genvar k = 0; k < N_SRC; k++) begin : g_tap
            if (k < N_INT_SRC) begin : g_int
                localparam int TAP = tap_of(SEL_W'(k));
                assign lvl_vec[k] = psc_q[TAP];
            end else begin : g_ext
                assign lvl_vec[k] = ext_lvl;
            end
        end
    endgenerate

    assign src_lvl = lvl_vec[sel];

    assert_psc_freeze_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(psc_q));
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        if (rise_sel) hit = lvl && !prev_q;
        else          hit = !lvl && prev_q;
    end
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             edge_hit,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             counting
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             fire, match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (start_evt) state_d = ST_ARM;
            ST_ARM:   state_d = stop_evt ? ST_HALT : ST_COUNT;
            ST_COUNT: if (stop_evt) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    always_comb begin
        counting = (state_q == ST_COUNT);
        fire     = counting && edge_hit;
        match    = fire && (cnt_q == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (start_evt) cnt_q <= '0;
        else if (match)     cnt_q <= '0;
        else if (fire)      cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (match)   flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !start_evt) |=> $stable(cnt_q));
    assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (cnt_q == '0 && state_q == ST_ARM));
    assert_match_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (flag_q && cnt_q == '0));
    assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !match) |=> !flag_q);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && match) |=> flag_q);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_tick,
    input  logic              ext_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic             start_q, pol_q, ien_q;
    logic [SEL_W-1:0] sel_q;
    logic [REG_W-1:0] cmp_q;
    logic             ctrl_wr, start_evt, stop_evt, clr_req;
    logic             ext_sync, src_lvl, edge_hit;
    logic [REG_W-1:0] cnt;
    logic             flag, counting;
    logic             unused_wbit;

    assign unused_wbit = reg_wdata[B_FLAG] ^ counting;

    always_comb begin
        ctrl_wr   = reg_we && (reg_addr == A_CTRL);
        start_evt = ctrl_wr && reg_wdata[B_START] && !start_q;
        stop_evt  = ctrl_wr && !reg_wdata[B_START];
        clr_req   = ctrl_wr && reg_wdata[B_CLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            pol_q   <= 1'b0;
            ien_q   <= 1'b0;
            sel_q   <= '0;
        end else if (ctrl_wr) begin
            start_q <= reg_wdata[B_START];
            pol_q   <= reg_wdata[B_POL];
            ien_q   <= reg_wdata[B_IEN];
            sel_q   <= reg_wdata[B_SEL +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cmp_q <= '0;
        else if (reg_we && reg_addr == A_CMP) cmp_q <= reg_wdata;
    end

    tmr_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .sync_out (ext_sync)
    );

    tmr_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_evt),
        .tick    (inst_tick),
        .sel     (sel_q),
        .ext_lvl (ext_sync),
        .src_lvl (src_lvl)
    );

    tmr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (src_lvl),
        .rise_sel (pol_q),
        .hit      (edge_hit)
    );

    tmr_count_fsm #(.CNT_W(REG_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .edge_hit  (edge_hit),
        .clr_req   (clr_req),
        .cmp_val   (cmp_q),
        .cnt       (cnt),
        .flag      (flag),
        .counting  (counting)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_START]         = start_q;
                reg_rdata[B_SEL +: SEL_W]  = sel_q;
                reg_rdata[B_POL]           = pol_q;
                reg_rdata[B_IEN]           = ien_q;
                reg_rdata[B_FLAG]          = flag;
            end
            A_CMP:   reg_rdata = cmp_q;
            A_CNT:   reg_rdata = cnt;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = ien_q && flag;

    assert_cmp_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CMP) |=> (cmp_q == $past(reg_wdata)));
endmodule

// File: tb/tick_cmp_timer_bench.sv
`timescale 1ns/100ps
module tick_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_tick = 1'b1;
    logic       ext_clk = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq;

    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    go = 1'b0;
    bit    done = 1'b0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    tick_cmp_timer u_tick_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .inst_tick (inst_tick),
        .ext_clk   (ext_clk),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int exp_lat(int code, bit pol, int c);
        int d;
        d = (code == 0) ? 2 : (code == 1) ? 4 : (code == 2) ? 16 :
            (code == 3) ? 64 : (code == 4) ? 128 : (code == 5) ? 256 : 512;
        return (pol ? d / 2 + 1 : d + 1) + c * d;
    endfunction

    // driver: program, start, push the expected irq latency to the scoreboard
    task automatic run_lat(int code, bit pol, int c, string req);
        wr(2'd1, 8'(c));
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h21 | (8'(pol) << 4) | (8'(code) << 1));
        exp_q.push_back(exp_lat(code, pol, c));
        tag_q.push_back(req);
        go = 1'b1;
        wait (done);
        done = 1'b0;
    endtask

    // monitor: counts edges after the start edge until irq appears
    initial begin
        forever begin
            int    e, n;
            bit    hit;
            string t;
            wait (go);
            go  = 1'b0;
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            n   = 0;
            hit = 1'b0;
            while (n < 4000 && !hit) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                hit = irq;
            end
            check(t, hit ? n : -1, e);
            done = 1'b1;
        end
    end

    task automatic ext_pulses(int n);
        for (int i = 0; i < n; i++) begin
            repeat (6) @(negedge clk);
            ext_clk = 1'b1;
            repeat (6) @(negedge clk);
            ext_clk = 1'b0;
        end
        repeat (8) @(posedge clk);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, rv); check("R1 ctrl", rv, 0);
        rd(2'd1, rv); check("R1 cmp", rv, 0);
        rd(2'd2, rv); check("R1 cnt", rv, 0);
        check("R1 irq", irq, 0);

        // R12 address map
        wr(2'd1, 8'hA5);
        rd(2'd1, rv); check("R12 cmp readback", rv, 8'hA5);
        rd(2'd3, rv); check("R12 spare addr", rv, 0);

        // R8 flag is read-only, R9 clear bit reads 0
        wr(2'd0, 8'h80);
        rd(2'd0, rv); check("R8 flag write ignored", rv, 0);
        wr(2'd0, 8'h70);
        rd(2'd0, rv); check("R9 clear bit reads 0", rv, 8'h30);

        // R4 / R6 latency scoreboard over every internal code
        run_lat(0, 1'b1, 3, "R4 code0 rise");
        run_lat(0, 1'b0, 3, "R6 code0 fall");
        run_lat(1, 1'b1, 5, "R4 code1 rise");
        run_lat(2, 1'b1, 4, "R4 code2 rise");
        run_lat(3, 1'b0, 2, "R6 code3 fall");
        run_lat(4, 1'b1, 0, "R4 code4 rise");
        run_lat(5, 1'b0, 1, "R6 code5 fall");
        run_lat(6, 1'b1, 1, "R4 code6 rise");

        // R7 reload to zero at match, flag set
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h11);
        repeat (5) @(posedge clk);
        rd(2'd2, rv); check("R7 count before match", rv, 2);
        @(posedge clk);
        #1;
        rd(2'd2, rv); check("R7 reload to zero", rv, 0);
        rd(2'd0, rv); check("R7 flag set", rv[7], 1);

        // R10 set beats clear in the same cycle (match on E8)
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h11);
        repeat (7) @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h51; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
        rd(2'd0, rv); check("R10 set wins", rv, 8'h91);
        check("R11 irq masked", irq, 0);
        wr(2'd0, 8'h31);
        rd(2'd0, rv); check("R11 irq follows flag", irq, 1);
        wr(2'd0, 8'h71);
        rd(2'd0, rv); check("R9 clear works", rv, 8'h31);
        check("R11 irq drops", irq, 0);

        // R3 start clears, rewrite does not; R2 halt holds
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h11);
        repeat (20) @(posedge clk);
        rd(2'd2, rv); check("R3 count after start", rv, 10);
        wr(2'd0, 8'h11);
        repeat (8) @(posedge clk);
        rd(2'd2, rv); check("R3 rewrite no clear", rv, 15);
        wr(2'd0, 8'h10);
        repeat (20) @(posedge clk);
        rd(2'd2, rv); check("R2 halted hold", rv, 16);

        // R13 tick low freezes prescaler
        inst_tick = 1'b0;
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h11);
        repeat (30) @(posedge clk);
        rd(2'd2, rv); check("R13 no tick no count", rv, 0);
        inst_tick = 1'b1;

        // R5 external clock, rising; R6 falling
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h1F);
        ext_pulses(4);
        rd(2'd2, rv); check("R5 ext rising count", rv, 4);
        wr(2'd0, 8'h40);
        wr(2'd0, 8'h0F);
        ext_pulses(3);
        rd(2'd2, rv); check("R6 ext falling count", rv, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule